// File: doc/BRIEF.md
# Last Value Prediction Table

This block guesses the result of a value-producing instruction before it executes. The guess is the value that the same instruction produced the last time it ran. A direct-mapped table holds one entry per slot. Each entry has a valid bit, an owner tag and one data word. The slot is chosen by folding the instruction address with XOR.

The lookup side is purely combinational. The core presents an instruction address on `lk_addr`. In the same cycle the block returns the value word of the selected slot on `pred_data`. It also returns `pred_hit`, which is high only when that slot is valid and its tag belongs to the address. No confidence qualification is applied to the hit.

The update side is used when an instruction retires. It writes the actual result together with the instruction address. If the tags match, only the value is refreshed. If they do not match, the slot changes owner. Every write lands on the next clock edge.

Top module: `lvp_table`

## Requirements
- R1: The slot index is the XOR of the low IDX_W address bits with the next IDX_W address bits. With the defaults (32-bit address, 16 slots) this is `addr[3:0] ^ addr[7:4]`. Two addresses whose folds agree select the same slot.
- R2: The tag stored and compared is `addr[ADDR_W-1:IDX_W]`. A lookup whose tag differs from the stored tag misses, even when the slot is valid.
- R3: `pred_data` always equals the value field of the selected slot, whether the lookup hits or misses. On a miss it therefore shows the value of whichever instruction owns that slot.
- R4: `pred_hit` is high exactly when the selected slot is valid and its tag equals the lookup tag. No other condition affects it.
- R5: An update whose tag matches the owner of the slot overwrites only the value. The next lookup of that address hits and returns the new value.
- R6: An update whose tag differs from the owner of the slot replaces both tag and value and sets the slot valid. Afterwards the new address hits, and the previous owner misses.
- R7: Reset (`rst_n` low, asynchronous) clears every slot to invalid with a zero value. After reset, every lookup misses with `pred_data` equal to 0 until that slot is written.
- R8: A lookup and an update to the same slot in the same cycle return the old contents. The written data becomes visible on the cycle after the edge.
- R9: The lookup has zero latency. The outputs follow `lk_addr` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_addr | input | ADDR_W | Instruction address to predict |
| pred_data | output | DATA_W | Value field of the selected slot |
| pred_hit | output | 1 | Slot valid and tag matches |
| upd_en | input | 1 | Write the retiring result this cycle |
| upd_addr | input | ADDR_W | Address of the retiring instruction |
| upd_data | input | DATA_W | Actual result of the retiring instruction |

## Verification
The vector walk first allocates a slot, then reads it back, then refreshes the same address. A refresh issued together with a lookup must still show the old word; this separates a write that lands at the edge from one that bypasses to the output. An alias address is then written into an occupied slot. It must evict the owner: the owner misses while still seeing the alias's value, which separates the tag check from the data path. Lookups of addresses that share a fold but not a tag, and a reset in the middle of the run, show that the index comes from the fold and that the valid bit gates the hit.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

    localparam int unsigned MAX_IDX_W = 16;

    // XOR fold of two adjacent address chunks of width idx_w
    function automatic logic [MAX_IDX_W-1:0] fold_xor(input logic [63:0] a,
                                                       input int unsigned idx_w);
        logic [MAX_IDX_W-1:0] r;
        r = '0;
        for (int unsigned i = 0; i < MAX_IDX_W; i++) begin
            if (i < idx_w) r[i] = a[i] ^ a[i + idx_w];
        end
        return r;
    endfunction

endpackage

// File: rtl/lvp_hash.sv
module lvp_hash #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic [lvp_pkg::MAX_IDX_W-1:0] folded;

    always_comb begin
        folded = lvp_pkg::fold_xor(64'(addr), IDX_W);
        idx    = folded[IDX_W-1:0];
        tag    = addr[ADDR_W-1:IDX_W];
    end
endmodule

// File: rtl/lvp_match.sv
module lvp_match #(
    parameter int unsigned TAG_W = 28
) (
    input  logic             slot_vld,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    always_comb hit = slot_vld && (slot_tag == req_tag);
endmodule

// File: rtl/lvp_store.sv
module lvp_store #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned TAG_W  = 28,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_val
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } state_t;

    state_t st_d, st_q;
    slot_t  wr_old;
    logic   wr_same_owner;

    always_comb begin
        st_d          = st_q;
        wr_old        = st_q.slot[wr_idx];
        wr_same_owner = wr_old.vld && (wr_old.tag == wr_tag);
        if (wr_en) begin
            if (wr_same_owner) begin
                st_d.slot[wr_idx].val = wr_data;          // refresh value only
            end else begin
                st_d.slot[wr_idx].vld = 1'b1;             // new owner
                st_d.slot[wr_idx].tag = wr_tag;
                st_d.slot[wr_idx].val = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_vld = st_q.slot[rd_idx].vld;
        rd_tag = st_q.slot[rd_idx].tag;
        rd_val = st_q.slot[rd_idx].val;
    end
endmodule

// File: rtl/lvp_table.sv
module lvp_table #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [DATA_W-1:0] pred_data,
    output logic              pred_hit,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_data
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;
    localparam int unsigned NPORT = 2;   // 0: lookup, 1: update

    logic [ADDR_W-1:0] port_addr [NPORT];
    logic [IDX_W-1:0]  port_idx  [NPORT];
    logic [TAG_W-1:0]  port_tag  [NPORT];
    logic              rd_vld;
    logic [TAG_W-1:0]  rd_tag;

    always_comb begin
        port_addr[0] = lk_addr;
        port_addr[1] = upd_addr;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_hash
        lvp_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
            .addr (port_addr[p]),
            .idx  (port_idx[p]),
            .tag  (port_tag[p])
        );
    end

    lvp_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd_en),
        .wr_idx  (port_idx[1]),
        .wr_tag  (port_tag[1]),
        .wr_data (upd_data),
        .rd_idx  (port_idx[0]),
        .rd_vld  (rd_vld),
        .rd_tag  (rd_tag),
        .rd_val  (pred_data)
    );

    lvp_match #(.TAG_W(TAG_W)) u_match (
        .slot_vld (rd_vld),
        .slot_tag (rd_tag),
        .req_tag  (port_tag[0]),
        .hit      (pred_hit)
    );
endmodule

// File: rtl/lvp_table_chk.sv
module lvp_table_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_addr,
    input logic [DATA_W-1:0] pred_data,
    input logic              pred_hit,
    input logic              upd_en,
    input logic [ADDR_W-1:0] upd_addr,
    input logic [DATA_W-1:0] upd_data
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] lk_fold, up_fold;
    always_comb begin
        lk_fold = IDX_W'(lvp_pkg::fold_xor(64'(lk_addr), IDX_W));
        up_fold = IDX_W'(lvp_pkg::fold_xor(64'(upd_addr), IDX_W));
    end

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en) && lk_addr == $past(upd_addr))
        |-> (pred_hit && pred_data == $past(upd_data))); // R5

    AST_ALIAS_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en) && lk_addr != $past(upd_addr)
         && lk_fold == $past(up_fold))
        |-> (!pred_hit && pred_data == $past(upd_data))); // R6

    AST_FRESH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pred_hit && pred_data == '0)); // R7

    AST_WRITE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd_en) && $stable(lk_addr))
        |-> ($stable(pred_data) && $stable(pred_hit))); // R8
endmodule

bind lvp_table lvp_table_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lk_addr),
    .pred_data (pred_data),
    .pred_hit  (pred_hit),
    .upd_en    (upd_en),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data)
);

// File: tb/test_lvp_table.sv
module test_lvp_table;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [DW-1:0] pred_data;
    logic          pred_hit;
    logic          upd_en = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic [DW-1:0] upd_data = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    lvp_table #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(16)) i_lvp_table (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .pred_data(pred_data),
        .pred_hit(pred_hit), .upd_en(upd_en), .upd_addr(upd_addr), .upd_data(upd_data)
    );

    typedef struct packed {
        logic          ue;
        logic [AW-1:0] ua;
        logic [DW-1:0] ud;
        logic [AW-1:0] la;
        logic          eh;
        logic [DW-1:0] ed;
    } vec_t;

    // Lookup result is sampled before the edge that applies the same row's update.
    // Slot = addr[3:0]^addr[7:4]; A=0x1234 and B=0x5670 share slot 7; C=0xFF and D=0x11 share slot 0.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_1234, 32'h1111_1111, 32'h0000_1234, 1'b0, 32'h0},           // R7 empty, R8
        '{1'b0, 32'h0,         32'h0,         32'h0000_1234, 1'b1, 32'h1111_1111},   // R6 allocate
        '{1'b1, 32'h0000_1234, 32'h2222_2222, 32'h0000_1234, 1'b1, 32'h1111_1111},   // R8 old value
        '{1'b0, 32'h0,         32'h0,         32'h0000_1234, 1'b1, 32'h2222_2222},   // R5 refresh
        '{1'b1, 32'h0000_5670, 32'h3333_3333, 32'h0000_1234, 1'b1, 32'h2222_2222},   // R8
        '{1'b0, 32'h0,         32'h0,         32'h0000_1234, 1'b0, 32'h3333_3333},   // R6 evicted, R3
        '{1'b0, 32'h0,         32'h0,         32'h0000_5670, 1'b1, 32'h3333_3333},   // R6 new owner
        '{1'b1, 32'h0000_00FF, 32'hCAFE_F00D, 32'h0000_00FF, 1'b0, 32'h0},           // R7 slot 0 empty
        '{1'b0, 32'h0,         32'h0,         32'h0000_00FF, 1'b1, 32'hCAFE_F00D},   // R1 slot 0
        '{1'b0, 32'h0,         32'h0,         32'h0000_0011, 1'b0, 32'hCAFE_F00D},   // R2 R3 alias miss
        '{1'b0, 32'h0,         32'h0,         32'h0000_0070, 1'b0, 32'h3333_3333},   // R2 R4
        '{1'b1, 32'h0000_0070, 32'h0000_0044, 32'h0000_5670, 1'b1, 32'h3333_3333},   // R8
        '{1'b0, 32'h0,         32'h0,         32'h0000_5670, 1'b0, 32'h0000_0044},   // R6 R3
        '{1'b1, 32'hABCD_0012, 32'h0000_0055, 32'hABCD_0012, 1'b0, 32'h0},           // R1 slot 3 empty
        '{1'b0, 32'h0,         32'h0,         32'hABCD_0021, 1'b0, 32'h0000_0055}    // R1 same fold, R2
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        chk("R7 reset hit", {31'b0, pred_hit}, 32'h0);
        chk("R7 reset data", pred_data, 32'h0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            upd_en   = VECS[i].ue;
            upd_addr = VECS[i].ua;
            upd_data = VECS[i].ud;
            lk_addr  = VECS[i].la;
            #1;
            chk($sformatf("R4 hit vec %0d", i), {31'b0, pred_hit}, {31'b0, VECS[i].eh});
            chk($sformatf("R3 data vec %0d", i), pred_data, VECS[i].ed);
        end
        @(negedge clk) upd_en = 1'b0;

        // R9: output follows the lookup address with no clock edge in between
        @(negedge clk);
        lk_addr = 32'h0000_00FF;
        #0.5;
        chk("R9 zero latency data", pred_data, 32'hCAFE_F00D);
        lk_addr = 32'h0000_0070;
        #0.5;
        chk("R9 zero latency hit", {31'b0, pred_hit}, 32'h1);
        chk("R9 zero latency data2", pred_data, 32'h0000_0044);

        // R7: reset in mid-run clears every slot
        @(negedge clk) rst_n = 1'b0;
        #1;
        chk("R7 async clear hit", {31'b0, pred_hit}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        lk_addr = 32'h0000_00FF;
        #1;
        chk("R7 after reset hit", {31'b0, pred_hit}, 32'h0);
        chk("R7 after reset data", pred_data, 32'h0);

        // R5: refresh then immediate lookup on the next cycle
        @(negedge clk);
        upd_en = 1'b1; upd_addr = 32'h0000_00FF; upd_data = 32'h0BAD_BEEF;
        @(negedge clk);
        upd_en = 1'b0;
        #1;
        chk("R5 written hit", {31'b0, pred_hit}, 32'h1);
        chk("R5 written data", pred_data, 32'h0BAD_BEEF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule